// File: doc/BRIEF.md
# PS/2 Host Controller Register Interface

This block is the host-side register core of a PC-style keyboard and pointing-device controller. A byte-wide host bus reaches two ports. Address 0 is the data port. Address 1 is the command port on writes and the status port on reads. The block holds a mode byte and a status byte. It decodes host commands and remembers one command that is waiting for a parameter byte. It also chooses which of two device read queues answers a data-port read: the keyboard queue or the auxiliary queue.

Each queue reports whether it holds a byte and shows its head byte. The block pops a queue with a one-cycle strobe. It puts bytes into either queue, and sends bytes to either device, through valid strobes that are asserted during the host write cycle itself. The keyboard and auxiliary interrupt levels come from the registered queue-occupancy flags and the current mode byte.

Top module: `ps2_host_regs`

## Requirements
- R1: After reset the mode byte is 0x03, the status byte is 0x18, both interrupts are low and `translate_en` is low.
- R2: Status bit 0 is set when either queue holds data. Status bit 5 is set only when the auxiliary queue holds data and the keyboard queue is empty.
- R3: A data-port read returns the keyboard head and pulses `kbd_pop` whenever the keyboard queue holds data. It returns the auxiliary head and pulses `aux_pop` only when the auxiliary queue alone holds data. A status-port read pops nothing.
- R4: `aux_irq` is high only when the auxiliary queue alone holds data and mode bit 1 is set.
- R5: `kbd_irq` is high only when the keyboard queue holds data, mode bit 0 is set and mode bit 4 is clear.
- R6: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm a pending parameter. The next data-port write is consumed by that command, and the write after it is plain keyboard data again.
- R7: The parameter of 0x60 loads the mode byte, and `translate_en` follows mode bit 6. The parameter of 0xD2 is pushed into the keyboard queue. The parameter of 0xD3 is pushed into the auxiliary queue. The parameter of 0xD4 is sent to the auxiliary device. The parameter of 0xD1 is consumed with no strobe.
- R8: A data-port write with no pending parameter is sent to the keyboard device (`kbd_tx`).
- R9: Command responses are pushed into the keyboard queue. 0x20 pushes the mode byte. 0xAA sets status bit 2 and pushes 0x55. 0xA9 and 0xAB push 0x00. 0xC0 pushes 0x80.
- R10: 0xA7 sets mode bit 5 and 0xA8 clears it. 0xAD sets mode bit 4 and 0xAE clears it. The new interrupt level is visible in the cycle after the command write.
- R11: Status bit 3 is set by a recognised command write and cleared by a data-port write.
- R12: An unrecognised command code produces no strobe and changes neither the mode byte nor the status byte.
- R13: The status bits and the interrupts follow a change of queue occupancy one clock later. The read source and the pop strobe follow occupancy in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 1 | 0 = data port, 1 = command/status port |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte |
| kbd_avail | input | 1 | Keyboard read queue holds a byte |
| kbd_head | input | 8 | Keyboard read queue head |
| kbd_pop | output | 1 | Pop the keyboard read queue |
| aux_avail | input | 1 | Auxiliary read queue holds a byte |
| aux_head | input | 8 | Auxiliary read queue head |
| aux_pop | output | 1 | Pop the auxiliary read queue |
| kbd_push | output | 1 | Push `push_data` into the keyboard read queue |
| aux_push | output | 1 | Push `push_data` into the auxiliary read queue |
| push_data | output | 8 | Byte to push |
| kbd_tx | output | 1 | Send `tx_data` to the keyboard device |
| aux_tx | output | 1 | Send `tx_data` to the auxiliary device |
| tx_data | output | 8 | Byte to send |
| kbd_irq | output | 1 | Keyboard interrupt level |
| aux_irq | output | 1 | Auxiliary interrupt level |
| translate_en | output | 1 | Scan-code translation enable (mode bit 6) |

## Verification
Queue occupancy is driven in three patterns: both queues full, auxiliary queue alone, and both empty. These show the keyboard-first priority in the read data, the pop strobes, status bits 0 and 5 and the two interrupts. They also show the one-clock lag of the registered flags. Mode values that clear and set the enable bits, together with the disable/enable commands, separate the interrupt gating terms from the occupancy terms. Each parameter command is followed by two data writes, which shows where the parameter was routed and that plain keyboard data resumes afterwards. An unrecognised code is sent after a data write, so that an unwanted change to status bit 3 can be seen.

// File: rtl/ps2_host_regs.sv
module ps2_host_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       kbd_avail,
  input  logic [7:0] kbd_head,
  output logic       kbd_pop,
  input  logic       aux_avail,
  input  logic [7:0] aux_head,
  output logic       aux_pop,
  output logic       kbd_push,
  output logic       aux_push,
  output logic [7:0] push_data,
  output logic       kbd_tx,
  output logic       aux_tx,
  output logic [7:0] tx_data,
  output logic       kbd_irq,
  output logic       aux_irq,
  output logic       translate_en
);
  localparam logic [7:0] C_GET_MODE = 8'h20, C_SET_MODE = 8'h60;
  localparam logic [7:0] C_AUX_OFF = 8'hA7, C_AUX_ON = 8'hA8, C_AUX_TEST = 8'hA9;
  localparam logic [7:0] C_SELFTEST = 8'hAA, C_KBD_TEST = 8'hAB;
  localparam logic [7:0] C_KBD_OFF = 8'hAD, C_KBD_ON = 8'hAE, C_INPORT = 8'hC0;
  localparam logic [7:0] C_OUTPORT = 8'hD1, C_FAKE_KBD = 8'hD2, C_FAKE_AUX = 8'hD3;
  localparam logic [7:0] C_TO_AUX = 8'hD4, P_NONE = 8'h00;
  localparam logic [7:0] MODE_RST = 8'h03;

  logic [7:0] mode, param, status, rsp;
  logic       kbd_pend, aux_pend, selftest, cmd_flag;
  logic       rsp_v, latch_cmd, known;

  wire cmd_wr   = wr_en & addr;
  wire dat_wr   = wr_en & ~addr;
  wire aux_only = aux_pend & ~kbd_pend;
  wire sel_aux  = aux_avail & ~kbd_avail;

  assign status = {2'b00, aux_only, 1'b1, cmd_flag, selftest, 1'b0, kbd_pend | aux_pend};
  assign rdata  = addr ? status : (sel_aux ? aux_head : kbd_head);
  assign kbd_pop = rd_en & ~addr & ~sel_aux;
  assign aux_pop = rd_en & ~addr & sel_aux;

  assign kbd_irq = kbd_pend & mode[0] & ~mode[4];
  assign aux_irq = aux_only & mode[1];
  assign translate_en = mode[6];

  always_comb begin
    rsp_v = 1'b1;
    rsp   = 8'h00;
    case (wdata)
      C_GET_MODE:             rsp = mode;
      C_SELFTEST:             rsp = 8'h55;
      C_AUX_TEST, C_KBD_TEST: rsp = 8'h00;
      C_INPORT:               rsp = 8'h80;
      default:                rsp_v = 1'b0;
    endcase
  end

  assign latch_cmd = (wdata == C_SET_MODE) || (wdata == C_OUTPORT) || (wdata == C_FAKE_KBD) ||
                     (wdata == C_FAKE_AUX) || (wdata == C_TO_AUX);
  assign known = rsp_v || latch_cmd || (wdata == C_AUX_OFF) || (wdata == C_AUX_ON) ||
                 (wdata == C_KBD_OFF) || (wdata == C_KBD_ON);

  assign kbd_push  = (cmd_wr & rsp_v) | (dat_wr & (param == C_FAKE_KBD));
  assign aux_push  = dat_wr & (param == C_FAKE_AUX);
  assign push_data = cmd_wr ? rsp : wdata;
  assign kbd_tx    = dat_wr & (param == P_NONE);
  assign aux_tx    = dat_wr & (param == C_TO_AUX);
  assign tx_data   = wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= MODE_RST;
      param <= P_NONE;
      kbd_pend <= 1'b0;
      aux_pend <= 1'b0;
      selftest <= 1'b0;
      cmd_flag <= 1'b1;
    end else begin
      kbd_pend <= kbd_avail;
      aux_pend <= aux_avail;
      if (cmd_wr && known) begin
        cmd_flag <= 1'b1;
        if (latch_cmd) param <= wdata;
        case (wdata)
          C_AUX_OFF:  mode[5] <= 1'b1;
          C_AUX_ON:   mode[5] <= 1'b0;
          C_KBD_OFF:  mode[4] <= 1'b1;
          C_KBD_ON:   mode[4] <= 1'b0;
          C_SELFTEST: selftest <= 1'b1;
          default: ;
        endcase
      end
      if (dat_wr) begin
        cmd_flag <= 1'b0;
        param <= P_NONE;
        if (param == C_SET_MODE) mode <= wdata;
      end
    end
  end

  assert_kbd_irq_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_irq |-> $past(kbd_avail));
  assert_aux_irq_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    aux_irq |-> ($past(aux_avail) && !$past(kbd_avail)));
  assert_param_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |=> (kbd_tx || !dat_wr || !$past(dat_wr)) || !wr_en);
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kbd_push, aux_push, kbd_tx, aux_tx}));
  assert_selftest_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(cmd_wr && wdata == C_SELFTEST));
endmodule

// File: tb/tb_ps2_host_regs.sv
`timescale 1ns/1ps
module tb_ps2_host_regs;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, addr = 0;
  logic [7:0] wdata = 0, kbd_head = 8'h11, aux_head = 8'h22;
  logic kbd_avail = 0, aux_avail = 0;
  logic [7:0] rdata, push_data, tx_data;
  logic kbd_pop, aux_pop, kbd_push, aux_push, kbd_tx, aux_tx, kbd_irq, aux_irq, translate_en;
  int errors = 0, checks = 0;
  bit done = 0;
  logic s_kp, s_ap, s_kt, s_at;
  logic [7:0] s_pd, s_td;

  always #2 clk = ~clk;

  ps2_host_regs dut (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
    .kbd_avail, .kbd_head, .kbd_pop, .aux_avail, .aux_head, .aux_pop,
    .kbd_push, .aux_push, .push_data, .kbd_tx, .aux_tx, .tx_data,
    .kbd_irq, .aux_irq, .translate_en);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    #1;
    s_kp = kbd_push; s_ap = aux_push; s_pd = push_data;
    s_kt = kbd_tx; s_at = aux_tx; s_td = tx_data;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic status(output logic [7:0] v);
    addr = 1; #0.5; v = rdata;
  endtask

  task automatic get_mode(output logic [7:0] v);
    wr(1, 8'h20); v = s_pd;
  endtask

  task automatic pop(output logic [7:0] v, output logic kp, output logic ap);
    @(negedge clk);
    addr = 0; rd_en = 1; #1;
    v = rdata; kp = kbd_pop; ap = aux_pop;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    status(v); chk("R1 status", v, 8'h18);
    chk("R1 irqs", {kbd_irq, aux_irq, translate_en}, 3'b000);
    get_mode(v); chk("R1 mode", v, 8'h03);
  endtask

  task automatic t_sources;
    logic [7:0] v; logic kp, ap;
    @(negedge clk); kbd_avail = 1; aux_avail = 1;
    status(v); chk("R13 lag", v, 8'h18);
    @(negedge clk);
    status(v); chk("R2 both", v, 8'h19);
    chk("R5 kbd irq", {kbd_irq, aux_irq}, 2'b10);
    pop(v, kp, ap); chk("R3 kbd first", v, 8'h11); chk("R3 kbd pop", {kp, ap}, 2'b10);
    kbd_avail = 0; #1;
    pop(v, kp, ap); chk("R3 aux alone", v, 8'h22); chk("R13 aux pop", {kp, ap}, 2'b01);
    status(v); chk("R2 aux only", v, 8'h39);
    chk("R4 aux irq", {kbd_irq, aux_irq}, 2'b01);
    addr = 1; rd_en = 1; #1; chk("R3 status no pop", {kbd_pop, aux_pop}, 2'b00); rd_en = 0;
    aux_avail = 0; @(negedge clk);
    status(v); chk("R2 empty", v, 8'h18);
  endtask

  task automatic t_irq_mode;
    @(negedge clk); kbd_avail = 1;
    wr(1, 8'h60); wr(0, 8'h00); chk("R5 mode0 clear", kbd_irq, 0);
    wr(1, 8'h60); wr(0, 8'h01); chk("R5 mode0 set", kbd_irq, 1);
    wr(1, 8'hAD); chk("R10 kbd disable irq", kbd_irq, 0);
    wr(1, 8'hAE); chk("R10 kbd enable irq", kbd_irq, 1);
    kbd_avail = 0; aux_avail = 1; @(negedge clk);
    chk("R4 mode1 clear", aux_irq, 0);
    wr(1, 8'h60); wr(0, 8'h42); chk("R4 mode1 set", aux_irq, 1);
    chk("R7 translate", translate_en, 1);
    wr(1, 8'h60); wr(0, 8'h03); chk("R7 translate off", translate_en, 0);
    aux_avail = 0; @(negedge clk);
  endtask

  task automatic t_params;
    wr(1, 8'hD2); wr(0, 8'h5A);
    chk("R7 d2", {s_kp, s_ap, s_kt, s_at}, 4'b1000); chk("R7 d2 byte", s_pd, 8'h5A);
    wr(1, 8'hD3); wr(0, 8'h6B);
    chk("R7 d3", {s_kp, s_ap, s_kt, s_at}, 4'b0100); chk("R7 d3 byte", s_pd, 8'h6B);
    wr(1, 8'hD4); wr(0, 8'h7C);
    chk("R7 d4", {s_kp, s_ap, s_kt, s_at}, 4'b0001); chk("R7 d4 byte", s_td, 8'h7C);
    wr(1, 8'hD1); wr(0, 8'h8D);
    chk("R6 d1 consumed", {s_kp, s_ap, s_kt, s_at}, 4'b0000);
    wr(0, 8'h9E);
    chk("R6 latch cleared", {s_kp, s_ap, s_kt, s_at}, 4'b0010);
    chk("R8 kbd tx byte", s_td, 8'h9E);
  endtask

  task automatic t_responses;
    logic [7:0] v;
    wr(1, 8'hAA); chk("R9 selftest", {7'b0, s_kp}, 8'h01); chk("R9 55", s_pd, 8'h55);
    status(v); chk("R9 bit2", v, 8'h1C);
    wr(1, 8'hA9); chk("R9 a9", s_pd, 8'h00);
    wr(1, 8'hAB); chk("R9 ab", s_pd, 8'h00);
    wr(1, 8'hC0); chk("R9 c0", s_pd, 8'h80);
    wr(1, 8'hA7); get_mode(v); chk("R10 a7", v, 8'h23);
    wr(1, 8'hA8); get_mode(v); chk("R10 a8", v, 8'h03);
  endtask

  task automatic t_unknown;
    logic [7:0] v;
    wr(0, 8'h01); status(v); chk("R11 data clears", v, 8'h14);
    wr(1, 8'h42); chk("R12 no strobe", {s_kp, s_ap, s_kt, s_at}, 4'b0000);
    status(v); chk("R12 status", v, 8'h14);
    wr(0, 8'h02); chk("R12 no latch", {s_kp, s_ap, s_kt, s_at}, 4'b0010);
    get_mode(v); chk("R12 mode", v, 8'h03);
    status(v); chk("R11 cmd sets", v, 8'h1C);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_sources;
    t_irq_mode;
    t_params;
    t_responses;
    t_unknown;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule